// File: doc/BRIEF.md
# Wide-Register Host Write Collector

This block sits between a 32-bit host register bus and internal storage whose words are wider than one host access: 128-bit control registers and an SRAM organised in 64-bit words. Host writes to a wide target arrive one dword at a time. A single collector gathers those dwords and then commits the complete word to the internal side in one atomic transfer. Only one target address is tracked at a time, so interleaving partial writes to two wide targets loses data. That loss is reported on a debug pin.

Two register kinds bypass or bend the collecting rule. Narrow 32-bit registers are forwarded immediately. Per-page descriptor-pointer registers are 128 bits wide and write-only. A write to their top dword always commits them, and any lower dwords the collector does not hold for that register go out as zero. A lower-dword write that would clash with data held for another target is dropped. A narrow write to the timer-command register of page 0 also clears the collector. This reproduces a known flaw that software works around.

Wide-register reads are returned one dword per access. Reading dword 0 captures the whole 128-bit value, and reads of dwords 1 to 3 return that capture. The host side uses a valid/ready handshake. While a commit waits for the internal target, `h_ready` stays low and every host access stalls. The commit port holds its payload until `c_ready`. Read responses are not back-pressured: `h_rvalid` pulses for one cycle.

Top module: `wide_write_gatherer`

## Requirements
- R1: After reset `c_valid`, `h_rvalid` and `dbg_lost` are 0 and `h_ready` is 1.
- R2: Address map for a byte address `a`:
  - SRAM is selected when `a[16]` is 1.
  - Otherwise the page is `a[15:13]` (stride 0x2000) and the offset is `a[12:0]`.
  - An offset below 0x400 is a normal 128-bit register.
  - Offsets 0x830 to 0x83F and 0xA10 to 0xA1F are descriptor registers.
  - Every other offset is a narrow 32-bit register.

  For a normal 128-bit register, `a[3:2]` selects the dword. The fourth distinct dword written, in any order, produces one commit with `c_kind`=1. `c_addr` is `a` with bits [3:0] cleared. Dword k is placed at `c_data[32k+31:32k]`. No commit happens before the fourth dword.
- R3: For SRAM, `a[2]` selects the half. Once both halves are collected, one commit is produced with `c_kind`=2 and `c_addr` equal to `a` with bits [2:0] cleared. `c_data[63:0]` holds {high, low} and `c_data[127:64]` is 0.
- R4: A normal-register or SRAM write whose aligned address differs from the one the collector holds discards the held data and starts over with the new write. In that case `dbg_lost` is 1 in the following cycle only.
- R5: A write to dword 3 of a descriptor register always commits it with `c_kind`=1. Each lower dword that the collector holds for that same register is included, and every other lower dword is committed as 0. Data held for a different target is left untouched.
- R6: A write to dword 0, 1 or 2 of a descriptor register is dropped while the collector holds data for another address. The collector state is unchanged and `dbg_lost` stays 0.
- R7: A narrow write produces a commit with `c_kind`=0. `c_addr` is `a` and `c_data` holds the write data in bits [31:0], with the rest zero. The collector is not affected.
- R8: A narrow write to offset 0x420 in page 0 empties the collector. The same offset in any other page does not.
- R9: While `c_valid` is 1 and `c_ready` is 0, the commit payload stays stable and `h_ready` is 0.
- R10: A read of dword 0 of a normal register presents `i_raddr` equal to the 16-byte-aligned address and returns `i_rdata[31:0]`. It also captures all of `i_rdata`. Reads of dwords 1 to 3 return the captured dword k, even if the target's value has since changed.
- R11: A read is answered by `h_rvalid` in the cycle after it is accepted.
  - Narrow reads: `i_raddr` is the 4-byte-aligned address and the response is `i_rdata[31:0]`.
  - SRAM reads: `i_raddr` is the 8-byte-aligned address and the response is the `i_rdata` dword selected by `a[2]`.
  - Descriptor reads return 0 without asserting `i_ren`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request accepted; low while a commit is pending |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Read response strobe, one cycle |
| h_rdata | output | 32 | Read response data |
| i_ren | output | 1 | Internal read strobe |
| i_raddr | output | ADDR_W | Internal read address |
| i_rdata | input | 128 | Internal read data, same cycle |
| c_valid | output | 1 | Commit valid |
| c_ready | input | 1 | Commit accepted by the target |
| c_kind | output | 2 | 0 narrow, 1 wide register, 2 SRAM word |
| c_addr | output | ADDR_W | Aligned commit address |
| c_data | output | 128 | Commit data |
| dbg_lost | output | 1 | Pulses when partial wide data is discarded |

## Verification
The bench builds the block with its default parameters. With a 17-bit address space there is one SRAM half and eight pages of 0x2000. This is enough to hit the timer-command offset both in page 0 and in page 1, and a descriptor register outside page 0. The internal target is modelled as an address-derived value with a changeable salt, so a dword-0 capture can be told apart from later live data. Commit back-pressure alternates between always-ready and ready every third cycle, so host stalls and payload holding are both exercised.

// File: rtl/wwg_pkg.sv
package wwg_pkg;
  localparam int LANE_W  = 32;
  localparam int LANES   = 4;
  localparam int WIDE_W  = LANE_W * LANES;

  typedef enum logic [1:0] {
    CK_NARROW = 2'd0,
    CK_WIDE   = 2'd1,
    CK_SRAM   = 2'd2
  } commit_kind_e;

  typedef enum logic [1:0] {
    AC_NARROW = 2'd0,
    AC_WIDE   = 2'd1,
    AC_DESC   = 2'd2,
    AC_SRAM   = 2'd3
  } addr_class_e;

  typedef logic [LANES-1:0][LANE_W-1:0] wide_word_t;
endpackage

// File: rtl/wwg_addr_decode.sv
module wwg_addr_decode
  import wwg_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int PAGE_SHIFT  = 13,
  parameter int NARROW_BASE = 'h400,
  parameter int RXD_OFF     = 'h830,
  parameter int TXD_OFF     = 'hA10,
  parameter int TMR_OFF     = 'h420
) (
  input  logic [ADDR_W-1:0] addr,
  output addr_class_e       cls,
  output logic              tmr_page0,
  output logic [ADDR_W-1:0] base,
  output logic [1:0]        dw
);
  localparam int OFF_W = PAGE_SHIFT;
  localparam logic [OFF_W-1:0] RXD_L = OFF_W'(RXD_OFF);
  localparam logic [OFF_W-1:0] TXD_L = OFF_W'(TXD_OFF);
  localparam logic [OFF_W-1:0] TMR_L = OFF_W'(TMR_OFF);
  localparam logic [OFF_W-1:0] NRW_L = OFF_W'(NARROW_BASE);

  logic                     in_sram;
  logic [OFF_W-1:0]         off;
  logic [ADDR_W-2-OFF_W:0]  page;
  logic                     desc_hit;

  assign in_sram  = addr[ADDR_W-1];
  assign off      = addr[OFF_W-1:0];
  assign page     = addr[ADDR_W-2:OFF_W];
  assign desc_hit = (off[OFF_W-1:4] == RXD_L[OFF_W-1:4]) ||
                    (off[OFF_W-1:4] == TXD_L[OFF_W-1:4]);

  always_comb begin
    if (in_sram)          cls = AC_SRAM;
    else if (off < NRW_L) cls = AC_WIDE;
    else if (desc_hit)    cls = AC_DESC;
    else                  cls = AC_NARROW;
  end

  assign tmr_page0 = !in_sram && (page == '0) && (off == TMR_L);

  always_comb begin
    case (cls)
      AC_SRAM: begin
        base = {addr[ADDR_W-1:3], 3'b000};
        dw   = {1'b0, addr[2]};
      end
      AC_NARROW: begin
        base = {addr[ADDR_W-1:2], 2'b00};
        dw   = addr[3:2];
      end
      default: begin
        base = {addr[ADDR_W-1:4], 4'b0000};
        dw   = addr[3:2];
      end
    endcase
  end
endmodule

// File: rtl/wwg_collector.sv
module wwg_collector
  import wwg_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  addr_class_e       cls,
  input  logic              tmr_page0,
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        dw,
  input  logic [LANE_W-1:0] wdata,
  output logic              ev_valid,
  output commit_kind_e      ev_kind,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [WIDE_W-1:0] ev_data,
  output logic              dbg_lost
);
  logic              col_valid, nv;
  logic [ADDR_W-1:0] col_base, nb;
  logic [LANES-1:0]  col_mask, nm;
  wide_word_t        col_data, nd;
  logic              hit, lost;
  logic [WIDE_W-1:0] desc_word;

  assign hit = col_valid && (col_base == base);

  // descriptor commit word: held lanes of the same register, zero elsewhere
  for (genvar g = 0; g < LANES - 1; g++) begin : g_desc_lane
    assign desc_word[g*LANE_W +: LANE_W] =
      (hit && col_mask[g]) ? col_data[g] : '0;
  end
  assign desc_word[WIDE_W-1 -: LANE_W] = wdata;

  always_comb begin
    nv       = col_valid;
    nb       = col_base;
    nm       = col_mask;
    nd       = col_data;
    lost     = 1'b0;
    ev_valid = 1'b0;
    ev_kind  = CK_NARROW;
    ev_addr  = base;
    ev_data  = '0;
    if (wr_fire) begin
      case (cls)
        AC_NARROW: begin
          ev_valid            = 1'b1;
          ev_data[LANE_W-1:0] = wdata;
          if (tmr_page0) begin
            nv = 1'b0;
            nm = '0;
          end
        end
        AC_WIDE, AC_SRAM: begin
          if (!hit) begin
            lost = col_valid;
            nm   = '0;
            nd   = '0;
            nb   = base;
          end
          nm[dw] = 1'b1;
          nd[dw] = wdata;
          nv     = 1'b1;
          if ((cls == AC_WIDE && nm == '1) ||
              (cls == AC_SRAM && nm[1:0] == 2'b11)) begin
            ev_valid = 1'b1;
            ev_kind  = (cls == AC_WIDE) ? CK_WIDE : CK_SRAM;
            ev_data  = nd;
            nv       = 1'b0;
            nm       = '0;
          end
        end
        AC_DESC: begin
          if (dw == 2'd3) begin
            ev_valid = 1'b1;
            ev_kind  = CK_WIDE;
            ev_data  = desc_word;
            if (hit) begin
              nv = 1'b0;
              nm = '0;
            end
          end else if (!col_valid || hit) begin
            if (!hit) begin
              nm = '0;
              nd = '0;
              nb = base;
            end
            nm[dw] = 1'b1;
            nd[dw] = wdata;
            nv     = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_valid <= 1'b0;
      col_base  <= '0;
      col_mask  <= '0;
      col_data  <= '0;
      dbg_lost  <= 1'b0;
    end else begin
      col_valid <= nv;
      col_base  <= nb;
      col_mask  <= nm;
      col_data  <= nd;
      dbg_lost  <= lost;
    end
  end

  // R8
  tmr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && cls == AC_NARROW && tmr_page0) |=> !col_valid);

  // R4
  lost_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_lost |-> $past(col_valid));

  // R5
  desc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && cls == AC_DESC && dw == 2'd3) |-> ev_valid && ev_kind == CK_WIDE);
endmodule

// File: rtl/wwg_commit_stage.sv
module wwg_commit_stage
  import wwg_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  commit_kind_e      ev_kind,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [WIDE_W-1:0] ev_data,
  output logic              c_valid,
  input  logic              c_ready,
  output logic [1:0]        c_kind,
  output logic [ADDR_W-1:0] c_addr,
  output logic [WIDE_W-1:0] c_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_valid <= 1'b0;
      c_kind  <= '0;
      c_addr  <= '0;
      c_data  <= '0;
    end else if (ev_valid) begin
      c_valid <= 1'b1;
      c_kind  <= ev_kind;
      c_addr  <= ev_addr;
      c_data  <= ev_data;
    end else if (c_ready) begin
      c_valid <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && !c_ready) |=> c_valid && $stable(c_data) && $stable(c_addr) && $stable(c_kind));
endmodule

// File: rtl/wwg_read_path.sv
module wwg_read_path
  import wwg_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  addr_class_e       cls,
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        dw,
  output logic              i_ren,
  output logic [ADDR_W-1:0] i_raddr,
  input  logic [WIDE_W-1:0] i_rdata,
  output logic              h_rvalid,
  output logic [LANE_W-1:0] h_rdata
);
  wide_word_t live, snap;

  assign live    = i_rdata;
  assign i_ren   = rd_fire && (cls != AC_DESC);
  assign i_raddr = base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
      snap     <= '0;
    end else begin
      h_rvalid <= rd_fire;
      if (rd_fire) begin
        case (cls)
          AC_WIDE: begin
            if (dw == 2'd0) begin
              snap    <= live;
              h_rdata <= live[0];
            end else begin
              h_rdata <= snap[dw];
            end
          end
          AC_SRAM:  h_rdata <= live[dw];
          AC_DESC:  h_rdata <= '0;
          default:  h_rdata <= live[0];
        endcase
      end
    end
  end
endmodule

// File: rtl/wide_write_gatherer.sv
module wide_write_gatherer
  import wwg_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int PAGE_SHIFT  = 13,
  parameter int NARROW_BASE = 'h400,
  parameter int RXD_OFF     = 'h830,
  parameter int TXD_OFF     = 'hA10,
  parameter int TMR_OFF     = 'h420
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic              h_rvalid,
  output logic [31:0]       h_rdata,
  output logic              i_ren,
  output logic [ADDR_W-1:0] i_raddr,
  input  logic [127:0]      i_rdata,
  output logic              c_valid,
  input  logic              c_ready,
  output logic [1:0]        c_kind,
  output logic [ADDR_W-1:0] c_addr,
  output logic [127:0]      c_data,
  output logic              dbg_lost
);
  addr_class_e       cls;
  logic              tmr_page0;
  logic [ADDR_W-1:0] base;
  logic [1:0]        dw;
  logic              wr_fire, rd_fire;
  logic              ev_valid;
  commit_kind_e      ev_kind;
  logic [ADDR_W-1:0] ev_addr;
  logic [WIDE_W-1:0] ev_data;

  assign h_ready = !c_valid;
  assign wr_fire = h_valid && h_ready && h_write;
  assign rd_fire = h_valid && h_ready && !h_write;

  wwg_addr_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NARROW_BASE(NARROW_BASE),
    .RXD_OFF(RXD_OFF), .TXD_OFF(TXD_OFF), .TMR_OFF(TMR_OFF)
  ) dec_i (
    .addr(h_addr), .cls(cls), .tmr_page0(tmr_page0), .base(base), .dw(dw)
  );

  wwg_collector #(.ADDR_W(ADDR_W)) col_i (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .cls(cls),
    .tmr_page0(tmr_page0), .base(base), .dw(dw), .wdata(h_wdata),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr),
    .ev_data(ev_data), .dbg_lost(dbg_lost)
  );

  wwg_commit_stage #(.ADDR_W(ADDR_W)) cs_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_addr(ev_addr), .ev_data(ev_data), .c_valid(c_valid),
    .c_ready(c_ready), .c_kind(c_kind), .c_addr(c_addr), .c_data(c_data)
  );

  wwg_read_path #(.ADDR_W(ADDR_W)) rp_i (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .cls(cls), .base(base),
    .dw(dw), .i_ren(i_ren), .i_raddr(i_raddr), .i_rdata(i_rdata),
    .h_rvalid(h_rvalid), .h_rdata(h_rdata)
  );

  // R2
  commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_valid) |-> $past(h_valid && h_write));

  // R11
  rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid |-> $past(h_valid && !h_write && h_ready));
endmodule

// File: tb/wide_write_gatherer_tb_top.sv
module wide_write_gatherer_tb_top;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          h_valid = 1'b0, h_write = 1'b0;
  logic [AW-1:0] h_addr = '0;
  logic [31:0]   h_wdata = '0;
  logic          h_ready, h_rvalid, i_ren, c_valid, dbg_lost;
  logic [31:0]   h_rdata;
  logic [AW-1:0] i_raddr, c_addr;
  logic [127:0]  i_rdata, c_data;
  logic [1:0]    c_kind;
  logic          c_ready = 1'b0;
  logic [31:0]   salt = 32'h0;

  always #4 clk = ~clk;

  wide_write_gatherer dut_i (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
    .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rvalid(h_rvalid), .h_rdata(h_rdata), .i_ren(i_ren),
    .i_raddr(i_raddr), .i_rdata(i_rdata), .c_valid(c_valid),
    .c_ready(c_ready), .c_kind(c_kind), .c_addr(c_addr),
    .c_data(c_data), .dbg_lost(dbg_lost)
  );

  function automatic logic [127:0] model(input logic [AW-1:0] a, input logic [31:0] s);
    logic [127:0] m;
    for (int k = 0; k < 4; k++)
      m[32*k +: 32] = ({15'b0, a} * 32'h9E3779B1) ^ s ^ (32'(k + 1) * 32'h01010101);
    return m;
  endfunction
  assign i_rdata = model(i_raddr, salt);

  int vectors = 0, fails = 0, lost_cnt = 0, cyc = 0;
  bit bp_mode = 1'b0, done = 1'b0;

  typedef struct packed {
    logic [1:0]    kind;
    logic [AW-1:0] addr;
    logic [127:0]  data;
  } cexp_t;
  cexp_t cq[$];
  string ctag[$];
  logic [31:0] rq[$];
  string rtag[$];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_c(input logic [1:0] k, input logic [AW-1:0] a, input logic [127:0] d, input string tag);
    cexp_t e;
    e.kind = k; e.addr = a; e.data = d;
    cq.push_back(e);
    ctag.push_back(tag);
  endtask

  task automatic hwrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    h_valid = 1'b1; h_write = 1'b1; h_addr = a; h_wdata = d;
    while (!h_ready) @(negedge clk);
    @(posedge clk);
    #1 h_valid = 1'b0;
  endtask

  task automatic hread(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    rq.push_back(exp);
    rtag.push_back(tag);
    @(negedge clk);
    h_valid = 1'b1; h_write = 1'b0; h_addr = a;
    while (!h_ready) @(negedge clk);
    @(posedge clk);
    #1 h_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 60; i++) begin
      if (cq.size() == 0 && rq.size() == 0 && !c_valid) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(cq.size() == 0 && rq.size() == 0, tag, 128'(cq.size() + rq.size()), 128'd0);
  endtask

  // monitor: drives target back-pressure and compares results
  always @(negedge clk) begin
    if (rst_n) begin
      c_ready = bp_mode ? (cyc % 3 == 0) : 1'b1;
      cyc++;
      if (c_valid) chk(!h_ready, "R9 host stall", 128'(h_ready), 128'd0);
      if (c_valid && c_ready) begin
        if (cq.size() == 0) begin
          chk(1'b0, "R2 unexpected commit", c_data, 128'd0);
        end else begin
          cexp_t e;
          string t;
          e = cq.pop_front();
          t = ctag.pop_front();
          chk(c_kind == e.kind, {t, " kind"}, 128'(c_kind), 128'(e.kind));
          chk(c_addr == e.addr, {t, " addr"}, 128'(c_addr), 128'(e.addr));
          chk(c_data == e.data, {t, " data"}, c_data, e.data);
        end
      end
      if (h_rvalid) begin
        if (rq.size() == 0) begin
          chk(1'b0, "R11 unexpected response", 128'(h_rdata), 128'd0);
        end else begin
          logic [31:0] ev;
          string t;
          ev = rq.pop_front();
          t = rtag.pop_front();
          chk(h_rdata == ev, t, 128'(h_rdata), 128'(ev));
        end
      end
      if (dbg_lost) lost_cnt++;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [127:0] snapv;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!c_valid && !h_rvalid && !dbg_lost && h_ready, "R1 reset",
        {124'd0, c_valid, h_rvalid, dbg_lost, h_ready}, 128'd1);
    rst_n = 1'b1;

    // R2: normal wide register, dwords out of order
    hwrite(17'h00108, 32'hA2A2A2A2);
    hwrite(17'h00100, 32'hA0A0A0A0);
    hwrite(17'h0010C, 32'hA3A3A3A3);
    expect_c(2'd1, 17'h00100, {32'hA3A3A3A3, 32'hA2A2A2A2, 32'hA0A1A0A1, 32'hA0A0A0A0}, "R2 wide");
    hwrite(17'h00104, 32'hA0A1A0A1);
    drain("R2 drain");

    // R3: SRAM word with back-pressure (R9)
    bp_mode = 1'b1;
    hwrite(17'h1000C, 32'h5151C0DE);
    expect_c(2'd2, 17'h10008, {64'd0, 32'h5151C0DE, 32'h10101010}, "R3 sram");
    hwrite(17'h10008, 32'h10101010);
    expect_c(2'd0, 17'h00404, {96'd0, 32'h0000BEEF}, "R9 stalled narrow");
    hwrite(17'h00404, 32'h0000BEEF);
    drain("R3 drain");
    bp_mode = 1'b0;

    // R4: conflicting partial write discards old data
    hwrite(17'h00200, 32'h20002000);
    hwrite(17'h00204, 32'h20042004);
    hwrite(17'h00300, 32'h30003000);
    hwrite(17'h00304, 32'h30043004);
    hwrite(17'h00308, 32'h30083008);
    expect_c(2'd1, 17'h00300, {32'h300C300C, 32'h30083008, 32'h30043004, 32'h30003000}, "R4 restart");
    hwrite(17'h0030C, 32'h300C300C);
    drain("R4 drain");
    chk(lost_cnt == 1, "R4 lost pulse", 128'(lost_cnt), 128'd1);

    // R5: descriptor top dword commits, missing lanes zero (page 1)
    hwrite(17'h02834, 32'hD1D1D1D1);
    expect_c(2'd1, 17'h02830, {32'hD3D3D3D3, 32'd0, 32'hD1D1D1D1, 32'd0}, "R5 desc partial");
    hwrite(17'h0283C, 32'hD3D3D3D3);
    expect_c(2'd1, 17'h00A10, {32'hE3E3E3E3, 96'd0}, "R5 desc top only");
    hwrite(17'h00A1C, 32'hE3E3E3E3);
    drain("R5 drain");

    // R6: descriptor low dword dropped while collector holds another target
    hwrite(17'h00100, 32'hF0F0F0F0);
    hwrite(17'h00830, 32'h60606060);
    expect_c(2'd1, 17'h00830, {32'h63636363, 96'd0}, "R6 dropped lane is zero");
    hwrite(17'h0083C, 32'h63636363);
    hwrite(17'h00104, 32'hF1F1F1F1);
    hwrite(17'h00108, 32'hF2F2F2F2);
    expect_c(2'd1, 17'h00100, {32'hF3F3F3F3, 32'hF2F2F2F2, 32'hF1F1F1F1, 32'hF0F0F0F0}, "R6 collector kept");
    hwrite(17'h0010C, 32'hF3F3F3F3);
    drain("R6 drain");
    chk(lost_cnt == 1, "R6 no lost pulse", 128'(lost_cnt), 128'd1);

    // R7: narrow write forwarded, collector untouched
    hwrite(17'h00040, 32'h70707070);
    hwrite(17'h00044, 32'h71717171);
    expect_c(2'd0, 17'h00400, {96'd0, 32'h7E7E7E7E}, "R7 narrow");
    hwrite(17'h00400, 32'h7E7E7E7E);
    hwrite(17'h00048, 32'h72727272);
    expect_c(2'd1, 17'h00040, {32'h73737373, 32'h72727272, 32'h71717171, 32'h70707070}, "R7 collector kept");
    hwrite(17'h0004C, 32'h73737373);
    drain("R7 drain");

    // R8: timer command in page 0 empties collector
    hwrite(17'h00050, 32'h80808080);
    hwrite(17'h00054, 32'h81818181);
    hwrite(17'h00058, 32'h82828282);
    expect_c(2'd0, 17'h00420, {96'd0, 32'h000000AA}, "R8 timer narrow");
    hwrite(17'h00420, 32'h000000AA);
    hwrite(17'h0005C, 32'h83838383);
    drain("R8 no commit after flush");
    hwrite(17'h00050, 32'h90909090);
    hwrite(17'h00054, 32'h91919191);
    expect_c(2'd1, 17'h00050, {32'h83838383, 32'h92929292, 32'h91919191, 32'h90909090}, "R8 refill");
    hwrite(17'h00058, 32'h92929292);
    drain("R8 drain");
    // R8: same offset in page 1 keeps collector
    hwrite(17'h00060, 32'hC0C0C0C0);
    expect_c(2'd0, 17'h02420, {96'd0, 32'h000000BB}, "R8 page1 timer");
    hwrite(17'h02420, 32'h000000BB);
    hwrite(17'h00064, 32'hC1C1C1C1);
    hwrite(17'h00068, 32'hC2C2C2C2);
    expect_c(2'd1, 17'h00060, {32'hC3C3C3C3, 32'hC2C2C2C2, 32'hC1C1C1C1, 32'hC0C0C0C0}, "R8 page1 kept");
    hwrite(17'h0006C, 32'hC3C3C3C3);
    drain("R8 page1 drain");
    chk(lost_cnt == 1, "R8 no lost pulse", 128'(lost_cnt), 128'd1);

    // R10: snapshot on dword 0
    salt = 32'h11110000;
    snapv = model(17'h00100, salt);
    hread(17'h00100, snapv[31:0], "R10 dword0");
    @(negedge clk);
    salt = 32'h22220000;
    hread(17'h00104, snapv[63:32], "R10 dword1 snapshot");
    hread(17'h00108, snapv[95:64], "R10 dword2 snapshot");
    hread(17'h0010C, snapv[127:96], "R10 dword3 snapshot");
    snapv = model(17'h00100, salt);
    hread(17'h00100, snapv[31:0], "R10 fresh dword0");
    // R11: other read classes
    snapv = model(17'h02400, salt);
    hread(17'h02400, snapv[31:0], "R11 narrow read");
    snapv = model(17'h10008, salt);
    hread(17'h1000C, snapv[63:32], "R11 sram high read");
    hread(17'h00834, 32'd0, "R11 descriptor read");
    drain("R11 drain");

    finish_run();
  end
endmodule